// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Engine

This block is the host side of a read path to a serial NOR flash. A single `start` pulse, together with a 24-bit start address, a byte count and a lane mode, launches one read transaction. The engine lowers the active-low select, sends a read opcode and the address one bit per clock on lane 0, runs eight dummy clocks, and then collects data on one, two or four lanes. Each byte it collects is handed out on `rd_data` together with a one-cycle `rd_valid` strobe.

The serial clock is derived from the system clock by a programmable half-period divider. The serial clock idles low (clock mode 0). The flash samples on rising edges, and the engine changes what it drives only on falling edges. Each of the four lanes has its own output-enable. The engine releases lane 0 before the dummy clocks begin, so that the flash can take the lanes over. `busy` covers the whole transaction, including the closing pause with select high. `done` marks the cycle in which the engine becomes free again.

Top module: `spi_mio_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sio_oe` is 0, and `busy`, `done` and `rd_valid` are 0.
- R2: `sclk` is 0 whenever `cs_n` is 1. While `cs_n` stays 0, `sio_out` changes only in the cycle where `sclk` falls.
- R3: A transaction begins with 32 clocks on lane 0, with only `sio_oe[0]` set. The first 8 bits are the opcode and the next 24 bits are the address, both MSB first. The opcode depends on `mode`: 2'b00 sends 0x0B, 2'b01 sends 0x3B, and 2'b10 or 2'b11 sends 0x6B.
- R4: Eight dummy clocks follow the address. From the falling edge that ends the address until the next transaction, `sio_oe` is 0.
- R5: In single mode, data is sampled from `sio_in[1]` on rising edges, MSB first, at 8 clocks per byte.
- R6: In dual mode, each clock carries two bits of a byte: `sio_in[1]` carries the odd bit and `sio_in[0]` the even bit. Pair (7,6) comes first, and a byte takes 4 clocks.
- R7: In quad mode, the high nibble comes first and then the low nibble, each on `sio_in[3:0]` with lane 3 as the nibble's MSB. A byte takes 2 clocks.
- R8: `len_m1` holds the byte count minus one, so the range is 1 to 65536 bytes. Exactly that many `rd_valid` pulses occur, one per byte, all while `cs_n` is 0. A transaction has exactly 40 + bytes×(8/lanes) rising edges.
- R9: Each serial-clock half period lasts `clk_div`+1 system clocks. This holds from select falling to the first rising edge and between every pair of clock edges. `clk_div` is captured at start.
- R10: After the last falling edge, `cs_n` rises one half period later with `sclk` held low. `cs_n` then stays high for at least 4 half periods before the next transaction. `done` pulses for one cycle, in the cycle where `busy` falls.
- R11: A `start` pulse while `busy` is 1 is ignored, including one that arrives during the closing pause. Select falls only for a `start` accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only when idle |
| addr | input | 24 | Flash start address |
| len_m1 | input | 16 | Byte count minus one |
| mode | input | 2 | Lane mode: 00 single, 01 dual, 1x quad |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low flash select |
| sio_out | output | 4 | Lane output values |
| sio_oe | output | 4 | Lane output enables |
| sio_in | input | 4 | Lane input values |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Two events can meet in the same period: a new launch request, and the closing sequence of the running transfer (the last data edge, select rising, and the pause before idle). The bench provokes this overlap in two ways. It pulses `start` with different address, mode and divider values in the middle of a transfer and again while select is already high but `busy` still holds. It also issues the next request immediately after `done`. A behavioural flash model and per-cycle reference checks then judge the outcome. The model must decode only the original opcode and address, and the byte stream must match the original request. No select edge may follow the ignored pulse, and the select-high gap before a back-to-back launch must not fall short of four half periods.

// File: rtl/spi_mio_reader.sv
module spi_mio_reader #(
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [1:0]        mode,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe,
  input  logic [3:0]        sio_in,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done
);
  localparam int SH_W  = 8 + ADDR_W;
  localparam int CNT_W = LEN_W + 4;
  localparam logic [DIV_W-1:0] D1 = 1;
  localparam logic [CNT_W-1:0] C1 = 1;

  typedef enum logic [2:0] {S_IDLE, S_CA, S_DUM, S_DAT, S_FIN, S_GAP} st_t;
  st_t st;

  logic [DIV_W-1:0] div_q, dcnt;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       lg_q;
  logic [2:0]       bcnt;
  logic [7:0]       acc, nb;
  logic             oe_q;

  wire [1:0] lg_in = (mode == 2'b00) ? 2'd0 : (mode == 2'b01) ? 2'd1 : 2'd2;
  wire [7:0] opc   = (mode == 2'b00) ? 8'h0B : (mode == 2'b01) ? 8'h3B : 8'h6B;
  wire [2:0] cpb_m1 = 3'd7 >> lg_q;
  wire [CNT_W-1:0] dat_m1 =
    (({{(CNT_W-LEN_W){1'b0}}, len_q} + C1) << (2'd3 - lg_q)) - C1;

  wire tick    = (st != S_IDLE) && (dcnt == div_q);
  wire clocked = (st == S_CA) || (st == S_DUM) || (st == S_DAT);
  wire rise    = tick && clocked && !sclk;
  wire fall    = tick && sclk;

  always_comb begin
    case (lg_q)
      2'd0:    nb = {acc[6:0], sio_in[1]};
      2'd1:    nb = {acc[5:0], sio_in[1:0]};
      default: nb = {acc[3:0], sio_in[3:0]};
    endcase
  end

  assign sio_out = {3'b000, sh[SH_W-1]};
  assign sio_oe  = {3'b000, oe_q};
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sclk <= 1'b0; cs_n <= 1'b1; oe_q <= 1'b0;
      sh <= '0; cnt <= '0; dcnt <= '0; div_q <= '0; len_q <= '0;
      lg_q <= 2'd0; bcnt <= 3'd0; acc <= 8'h00; rd_data <= 8'h00;
      rd_valid <= 1'b0; done <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_CA; cs_n <= 1'b0; oe_q <= 1'b1;
          sh <= {opc, addr}; cnt <= CNT_W'(SH_W - 1); dcnt <= '0;
          div_q <= clk_div; len_q <= len_m1; lg_q <= lg_in;
        end
      end else begin
        dcnt <= tick ? '0 : dcnt + D1;
        if (tick && clocked) sclk <= !sclk;
        if (rise && st == S_DAT) begin
          acc <= nb;
          if (bcnt == 3'd0) begin
            rd_data <= nb; rd_valid <= 1'b1; bcnt <= cpb_m1;
          end else bcnt <= bcnt - 3'd1;
        end
        if (fall) begin
          case (st)
            S_CA:
              if (cnt == '0) begin st <= S_DUM; cnt <= CNT_W'(7); oe_q <= 1'b0; end
              else begin sh <= sh << 1; cnt <= cnt - C1; end
            S_DUM:
              if (cnt == '0) begin st <= S_DAT; cnt <= dat_m1; bcnt <= cpb_m1; end
              else cnt <= cnt - C1;
            S_DAT:
              if (cnt == '0) st <= S_FIN;
              else cnt <= cnt - C1;
            default: ;
          endcase
        end
        if (tick && st == S_FIN) begin
          cs_n <= 1'b1; st <= S_GAP; cnt <= CNT_W'(3);
        end
        if (tick && st == S_GAP) begin
          if (cnt == '0) begin st <= S_IDLE; done <= 1'b1; end
          else cnt <= cnt - C1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mio_reader_chk.sv
module spi_mio_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] sio_out,
  input logic [3:0] sio_oe,
  input logic       rd_valid
);
  assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && (sio_out != $past(sio_out))) |-> ($past(sclk) && !sclk));

  assert_released_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sio_oe == 4'b0000));

  assert_valid_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n);

  assert_done_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));

  assert_cs_rise_clock_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk)));

  assert_launch_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && !$past(busy)));
endmodule

bind spi_mio_reader spi_mio_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cs_n(cs_n), .sclk(sclk), .sio_out(sio_out), .sio_oe(sio_oe),
  .rd_valid(rd_valid)
);

// File: tb/tb_spi_mio_reader.sv
module tb_spi_mio_reader;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] len_m1 = '0;
  logic [1:0]  mode = '0;
  logic [7:0]  clk_div = '0;
  logic [3:0]  sio_in = '0;
  logic        sclk, cs_n, rd_valid, busy, done;
  logic [3:0]  sio_out, sio_oe;
  logic [7:0]  rd_data;

  spi_mio_reader dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(logic [23:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] opc_of(logic [1:0] m);
    return (m == 2'b00) ? 8'h0B : (m == 2'b01) ? 8'h3B : 8'h6B;
  endfunction

  function automatic int lanes_of(logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  function automatic string req_of(logic [1:0] m);
    return (m == 2'b00) ? "R5" : (m == 2'b01) ? "R6" : "R7";
  endfunction

  // expected transaction
  logic [1:0]  e_mode = '0;
  logic [23:0] e_addr = '0;
  int          e_n = 0, e_div = 0;
  logic [7:0]  q[$];

  // behavioural flash model and per-cycle reference
  int          rc = 0, dclk = 0, half = 0, gap = 0, gap_need = 0;
  bit          gap_valid = 0;
  logic [31:0] fsh = '0;
  logic        pcs = 1'b1, psclk = 1'b0;
  logic [3:0]  pout = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(cs_n && sclk), "R2", "sclk while deselected", sclk, 0);
      if (!cs_n && !pcs && sio_out != pout)
        chk(psclk && !sclk, "R2", "sio_out change off falling edge", sclk, 0);

      if (pcs && !cs_n) begin
        rc = 0; dclk = 0; half = 0; sio_in = 4'b0000;
        if (gap_valid) chk(gap >= gap_need, "R10", "select high gap", gap, gap_need);
      end else if (!pcs && cs_n) begin
        chk(half == e_div, "R10", "select rise delay", half, e_div);
        chk(rc == 40 + e_n * (8 / lanes_of(e_mode)), "R8", "rising edge count",
            rc, 40 + e_n * (8 / lanes_of(e_mode)));
        gap = 0; gap_valid = 1; gap_need = 4 * (e_div + 1);
      end else if (!cs_n) begin
        if (sclk != psclk) begin
          chk(half == e_div, "R9", "half period", half + 1, e_div + 1);
          half = 0;
          if (sclk) begin
            rc++;
            if (rc <= 32) begin
              chk(sio_oe == 4'b0001, "R3", "lane enables in command", sio_oe, 1);
              fsh = {fsh[30:0], sio_out[0]};
              if (rc == 32) begin
                chk(fsh[31:24] == opc_of(e_mode), "R3", "opcode", fsh[31:24], opc_of(e_mode));
                chk(fsh[23:0] == e_addr, "R3", "address", fsh[23:0], e_addr);
              end
            end else begin
              chk(sio_oe == 4'b0000, "R4", "lanes released", sio_oe, 0);
            end
          end else if (rc >= 40) begin
            int w, cpb, b, p;
            logic [7:0] v;
            w = lanes_of(e_mode); cpb = 8 / w;
            b = dclk / cpb; p = dclk % cpb;
            v = fbyte(e_addr + 24'(b));
            case (w)
              1: begin sio_in[1] = v[7-p]; sio_in[0] = ~v[7-p]; sio_in[3:2] = {v[7-p], 1'b1}; end
              2: begin sio_in[1:0] = {v[7-2*p], v[6-2*p]}; sio_in[3:2] = ~{v[7-2*p], v[6-2*p]}; end
              default: sio_in = (p == 0) ? v[7:4] : v[3:0];
            endcase
            dclk++;
          end
        end else half++;
      end
      if (cs_n) gap++;

      if (rd_valid) begin
        if (q.size() == 0) chk(0, "R8", "extra byte", rd_data, 0);
        else begin
          logic [7:0] ex;
          ex = q.pop_front();
          chk(rd_data == ex, req_of(e_mode), "read byte", rd_data, ex);
        end
      end
      pcs = cs_n; psclk = sclk; pout = sio_out;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic launch(logic [1:0] m, int dv, logic [23:0] a, int n);
    e_mode = m; e_div = dv; e_addr = a; e_n = n;
    for (int i = 0; i < n; i++) q.push_back(fbyte(a + 24'(i)));
    @(negedge clk);
    mode = m; clk_div = 8'(dv); addr = a; len_m1 = 16'(n - 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_xfer();
    while (!done) @(negedge clk);
    chk(!busy, "R10", "busy with done", busy, 0);
    chk(q.size() == 0, "R8", "bytes missing", q.size(), 0);
  endtask

  task automatic run(logic [1:0] m, int dv, logic [23:0] a, int n);
    launch(m, dv, a, n);
    finish_xfer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R1", "select/clock at reset", {cs_n, sclk}, 2);
    chk(sio_oe == 0 && !busy && !done && !rd_valid, "R1", "idle outputs at reset",
        {sio_oe, busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && !busy, "R1", "idle after reset", {cs_n, busy}, 2);

    run(2'b00, 0, 24'h123456, 4);      // R5 single, fastest divider
    run(2'b01, 1, 24'hABCDEF, 5);      // R6 dual
    run(2'b10, 2, 24'hFFFFFE, 3);      // R7 quad, address wrap in model
    run(2'b11, 0, 24'h000010, 1);      // R7 mode 11 quad, R8 single byte
    run(2'b01, 3, 24'h5A5A00, 64);     // R6, R9 slow divider
    run(2'b00, 0, 24'h00FF00, 300);    // R8 long single

    // R11: start while busy, mid-transfer and during closing gap
    launch(2'b10, 1, 24'h0C0FFE, 6);
    repeat (60) @(negedge clk);
    mode = 2'b00; clk_div = 8'd5; addr = 24'h777777; len_m1 = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!cs_n) @(negedge clk);
    chk(busy, "R11", "busy during closing gap", busy, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_xfer();
    begin
      int low = 0;
      repeat (30) begin @(negedge clk); if (!cs_n) low++; end
      chk(low == 0, "R11", "ignored start launched transfer", low, 0);
    end

    run(2'b01, 0, 24'h800000, 7);      // R10 back-to-back launch right after done
    run(2'b10, 0, 24'h800100, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule